// File: doc/BRIEF.md
# Pin Bank with Bitwise Set and Clear Register Aliases

This block is one bank of general-purpose pins with interrupt detection. Each control register answers at three word addresses: one where a write replaces the whole value, one where a write turns on the bits that are 1 in the data, and one where a write turns off those bits. Software can therefore change single pin bits without reading first, and several agents can update different bits of one register without lost updates.

The bank drives an output value and an output-enable per pin. It reads back the pad levels through a two-flop synchronizer. It also turns pad activity into a sticky per-pin status. Each pin has its own detection settings: a source-select bit, a level-or-edge bit and a polarity bit. One interrupt line is high while any enabled status bit is set. The status can only be cleared, and only through its clear address.

Top module: `gpio_alias_bank`

## Requirements
- R1: Address decode is `{reg[2:0], op[1:0], 2'b00}`. The registers are dout=0, oe=1, din=2, irq_en=3, src_sel=4, lvl_sel=5, pol_sel=6, status=7. The ops are 0 = replace, 1 = set, 2 = clear. A replace write loads a register, and a read at op 0, 1 or 2 returns its current value.
- R2: A write at op 1 ORs the written data into the register.
- R3: A write at op 2 clears every register bit that is 1 in the written data.
- R4: `pad_out` always carries the dout register and `pad_oe` the oe register. An oe bit of 1 means the pin is driven.
- R5: Reading din returns the pad levels after two synchronizer flops. A pad change is visible in a read after the second rising clock edge and not after the first. Writes to din have no effect.
- R6: Status bits are cleared only by op 2 writes to the status register. Replace writes and set writes to status are ignored.
- R7: A pin whose src_sel bit is 0 never sets its status bit, whatever its irq_en bit is.
- R8: Edge mode is lvl_sel=0. A pol_sel bit of 1 detects rising edges and 0 detects falling edges. The status bit reads 1 after the third rising clock edge following the pad change, and still reads 0 after the second. The opposite edge sets nothing.
- R9: Level mode is lvl_sel=1. The status bit is set on every cycle that the synchronized pad equals the pol_sel bit, so a clear does not stick while that level persists.
- R10: `irq` is 1 exactly when some bit is 1 in both status and irq_en.
- R11: A detection and a clear write on the same status bit in the same cycle leave the bit set.
- R12: Writes at op 3, or at an address with a nonzero byte offset, change nothing. Reads there return zero.
- R13: After reset every register, `pad_out`, `pad_oe` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for bus_addr (combinational) |
| pad_in | input | WIDTH | Asynchronous pad levels |
| pad_out | output | WIDTH | Output values for the pads |
| pad_oe | output | WIDTH | Per-pin drive enables |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted register bit reaches `pad_out` or `pad_oe` on the cycle after the write, and it shows in any read at the three aliases at once. A wrong synchronizer depth or a wrong edge history moves the first cycle in which the status read turns 1. The checks therefore sample both one cycle before and exactly at the expected cycle. A status bit that is set wrongly or cleared wrongly reaches `irq` in the same cycle that the bit changes. This happens only when that pin's irq_en bit is set, so the masking is checked separately.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_RSVD  = 2'd3
    } alias_op_e;

    typedef enum logic [2:0] {
        RG_DOUT = 3'd0,
        RG_OE   = 3'd1,
        RG_DIN  = 3'd2,
        RG_IEN  = 3'd3,
        RG_SRC  = 3'd4,
        RG_LVL  = 3'd5,
        RG_POL  = 3'd6,
        RG_STAT = 3'd7
    } reg_sel_e;

    localparam int NUM_REGS = 8;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous sample
    typedef struct packed {
        logic [STAGES:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = pad_in;
        for (int i = 1; i <= STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.chain[STAGES-1];
    assign prev = s_q.chain[STAGES];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] src_sel,
    input  logic [W-1:0] lvl_sel,
    input  logic [W-1:0] pol_sel,
    output logic [W-1:0] hit
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic lvl_match;
        logic rise;
        logic fall;
        logic edge_match;

        always_comb begin
            lvl_match  = (cur[p] == pol_sel[p]);
            rise       = cur[p] & ~prev[p];
            fall       = ~cur[p] & prev[p];
            edge_match = pol_sel[p] ? rise : fall;
            hit[p]     = src_sel[p] & (lvl_sel[p] ? lvl_match : edge_match);
        end
    end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int W      = 32,
    parameter bit STICKY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_wr,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } areg_t;

    areg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel_wr) begin
            case (op)
                OP_WRITE: if (!STICKY) r_d.val = wdata;
                OP_SET:   if (!STICKY) r_d.val = r_q.val | wdata;
                OP_CLR:   r_d.val = r_q.val & ~wdata;
                default:  r_d.val = r_q.val;
            endcase
        end
        // hardware setting is applied last so it wins over a clear
        r_d.val = r_d.val | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q.val;
endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic              irq
);
    localparam int REG_BITS = 3;
    localparam int OP_LSB   = 2;
    localparam int REG_LSB  = OP_LSB + 2;

    logic [REG_BITS-1:0] reg_idx;
    alias_op_e           op;
    logic                aligned;
    logic [WIDTH-1:0]    reg_q [NUM_REGS];
    logic [WIDTH-1:0]    pin_cur;
    logic [WIDTH-1:0]    pin_prev;
    logic [WIDTH-1:0]    hit;
    logic [WIDTH-1:0]    stat_q;
    logic [WIDTH-1:0]    src_q;

    assign reg_idx = bus_addr[REG_LSB +: REG_BITS];
    assign op      = alias_op_e'(bus_addr[OP_LSB +: 2]);
    assign aligned = (bus_addr[OP_LSB-1:0] == '0);

    gpio_pad_sync #(.W(WIDTH), .STAGES(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .cur    (pin_cur),
        .prev   (pin_prev)
    );

    gpio_irq_detect #(.W(WIDTH)) i_detect (
        .cur     (pin_cur),
        .prev    (pin_prev),
        .src_sel (reg_q[RG_SRC]),
        .lvl_sel (reg_q[RG_LVL]),
        .pol_sel (reg_q[RG_POL]),
        .hit     (hit)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == int'(RG_DIN)) begin : g_ro
            assign reg_q[g] = pin_cur;
        end else begin : g_rw
            localparam bit IS_STAT = (g == int'(RG_STAT));
            logic sel_wr;
            assign sel_wr = bus_wr && aligned && (op != OP_RSVD) &&
                            (reg_idx == REG_BITS'(g));
            gpio_alias_reg #(.W(WIDTH), .STICKY(IS_STAT)) i_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel_wr (sel_wr),
                .op     (op),
                .wdata  (bus_wdata),
                .hw_set (IS_STAT ? hit : '0),
                .q      (reg_q[g])
            );
        end
    end

    always_comb begin
        if (!aligned || op == OP_RSVD) bus_rdata = '0;
        else                           bus_rdata = reg_q[reg_idx];
    end

    assign stat_q  = reg_q[RG_STAT];
    assign src_q   = reg_q[RG_SRC];
    assign pad_out = reg_q[RG_DOUT];
    assign pad_oe  = reg_q[RG_OE];
    assign irq     = |(stat_q & reg_q[RG_IEN]);
endmodule

// File: rtl/gpio_alias_bank_chk.sv
module gpio_alias_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  stat,
    input logic [WIDTH-1:0]  src,
    input logic              irq
);
    localparam logic [ADDR_W-1:0] A_OE_SET  = ADDR_W'({RG_OE,   OP_SET, 2'b00});
    localparam logic [ADDR_W-1:0] A_OE_CLR  = ADDR_W'({RG_OE,   OP_CLR, 2'b00});
    localparam logic [ADDR_W-1:0] A_ST_CLR  = ADDR_W'({RG_STAT, OP_CLR, 2'b00});

    p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OE_SET) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_OE_CLR) |=> ((pad_oe & $past(bus_wdata)) == '0));

    p_status_clear_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(stat) & ~stat) != '0)) |-> $past(bus_wr && bus_addr == A_ST_CLR));

    p_unselected_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & ~$past(src)) == '0));

    p_irq_needs_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != '0));
endmodule

bind gpio_alias_bank gpio_alias_bank_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .stat      (stat_q),
    .src       (src_q),
    .irq       (irq)
);

// File: tb/test_gpio_alias_bank.sv
module test_gpio_alias_bank;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 32;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out;
    logic [W-1:0]  pad_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_alias_bank #(.WIDTH(W), .ADDR_W(AW)) i_gpio_alias_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // register numbers and ops as stated in R1
    function automatic logic [AW-1:0] adr(input int rg, input int op);
        return AW'({rg[2:0], op[1:0], 2'b00});
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [W-1:0] v;
        for (int r = 0; r < 8; r++) begin
            rd(adr(r, 0), v);
            chk("R13 reg reset", v, '0);
        end
        chk("R13 pad_out reset", pad_out, '0);
        chk("R13 pad_oe reset", pad_oe, '0);
        chk("R13 irq reset", {31'd0, irq}, '0);
    endtask

    task automatic t_plain;
        logic [W-1:0] v;
        wr(adr(0, 0), 32'hA5A5_F00F);
        rd(adr(0, 0), v); chk("R1 dout base read", v, 32'hA5A5_F00F);
        rd(adr(0, 1), v); chk("R1 dout set-alias read", v, 32'hA5A5_F00F);
        rd(adr(0, 2), v); chk("R1 dout clr-alias read", v, 32'hA5A5_F00F);
        chk("R4 pad_out follows dout", pad_out, 32'hA5A5_F00F);
        wr(adr(2, 0), 32'hFFFF_FFFF);
        rd(adr(2, 0), v); chk("R5 din write ignored", v, '0);
    endtask

    task automatic t_set_clr;
        logic [W-1:0] v;
        wr(adr(1, 0), 32'h0000_FFFF);
        wr(adr(1, 1), 32'h00F0_0000);
        rd(adr(1, 0), v); chk("R2 set alias ORs", v, 32'h00F0_FFFF);
        wr(adr(1, 2), 32'h0000_00F0);
        rd(adr(1, 0), v); chk("R3 clr alias clears", v, 32'h00F0_FF0F);
        chk("R4 pad_oe follows oe", pad_oe, 32'h00F0_FF0F);
    endtask

    task automatic t_reserved;
        logic [W-1:0] v;
        wr(adr(1, 3), 32'hFFFF_FFFF);
        chk("R12 op3 write ignored", pad_oe, 32'h00F0_FF0F);
        rd(adr(1, 3), v); chk("R12 op3 reads zero", v, '0);
        wr(adr(1, 0) | AW'(1), 32'h0);
        chk("R12 misaligned write ignored", pad_oe, 32'h00F0_FF0F);
        rd(adr(1, 0) | AW'(2), v); chk("R12 misaligned read zero", v, '0);
    endtask

    task automatic t_din;
        logic [W-1:0] v;
        @(negedge clk); pad_in = 32'h1234_5670;
        @(negedge clk); rd(adr(2, 0), v); chk("R5 din not after one edge", v, '0);
        @(negedge clk); rd(adr(2, 0), v); chk("R5 din after two edges", v, 32'h1234_5670);
        pad_in = '0;
        idle(3);
    endtask

    task automatic t_edge_rise;
        logic [W-1:0] v;
        wr(adr(4, 1), 32'h1);  // source pin 0
        wr(adr(6, 1), 32'h1);  // rising
        wr(adr(3, 1), 32'h1);  // enable
        pad_in[0] = 1'b1;
        idle(2); rd(adr(7, 0), v); chk("R8 rising not yet", v, '0);
        idle(1); rd(adr(7, 0), v); chk("R8 rising latched at third edge", v, 32'h1);
        chk("R10 irq high", {31'd0, irq}, 32'h1);
        wr(adr(7, 0), 32'h0);
        rd(adr(7, 0), v); chk("R6 plain write ignored", v, 32'h1);
        wr(adr(7, 1), 32'h2);
        rd(adr(7, 0), v); chk("R6 set write ignored", v, 32'h1);
        pad_in[0] = 1'b0;
        wr(adr(7, 2), 32'h1);
        idle(3);
        rd(adr(7, 0), v); chk("R8 falling edge ignored in rising mode", v, '0);
        chk("R10 irq low", {31'd0, irq}, '0);
    endtask

    task automatic t_edge_fall;
        logic [W-1:0] v;
        wr(adr(4, 1), 32'h2);  // pin 1, pol 0, edge, not enabled
        pad_in[1] = 1'b1;
        idle(3); rd(adr(7, 0), v); chk("R8 rise ignored in falling mode", v, '0);
        pad_in[1] = 1'b0;
        idle(3); rd(adr(7, 0), v); chk("R8 falling latched", v, 32'h2);
        chk("R10 irq masked", {31'd0, irq}, '0);
        wr(adr(7, 2), 32'h2);
        rd(adr(7, 0), v); chk("R6 clear alias clears status", v, '0);
    endtask

    task automatic t_unselected;
        logic [W-1:0] v;
        wr(adr(3, 1), 32'h4);
        wr(adr(5, 1), 32'h4);
        wr(adr(6, 1), 32'h4);
        pad_in[2] = 1'b1;
        idle(4); rd(adr(7, 0), v); chk("R7 unselected pin no status", v, '0);
        chk("R7 unselected pin no irq", {31'd0, irq}, '0);
        pad_in[2] = 1'b0;
        idle(3);
    endtask

    task automatic t_level;
        logic [W-1:0] v;
        wr(adr(5, 1), 32'h8);
        wr(adr(6, 1), 32'h8);
        wr(adr(3, 1), 32'h8);
        wr(adr(4, 1), 32'h8);
        pad_in[3] = 1'b1;
        idle(3); rd(adr(7, 0), v); chk("R9 high level sets", v, 32'h8);
        wr(adr(7, 2), 32'h8);
        rd(adr(7, 0), v); chk("R11 detection beats clear", v, 32'h8);
        chk("R9 irq held by level", {31'd0, irq}, 32'h1);
        pad_in[3] = 1'b0;
        idle(3);
        wr(adr(7, 2), 32'h8);
        rd(adr(7, 0), v); chk("R9 clear sticks once level gone", v, '0);
        wr(adr(6, 2), 32'h8);
        idle(1);
        rd(adr(7, 0), v); chk("R9 low level sets", v, 32'h8);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_plain();
        t_set_clr();
        t_reserved();
        t_din();
        t_edge_rise();
        t_edge_fall();
        t_unselected();
        t_level();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule